// File: doc/BRIEF.md
# Monotonic Slewing Tick Accumulator

This block keeps a time-of-day count in microseconds. Each pulse on the periodic tick input adds a programmable nominal increment to the count. The host can load the count outright with a set command. It can also request a signed phase correction. The block does not apply a correction in one step. It spreads the correction over successive ticks: it adds the nominal increment plus a bounded slew delta for a forward correction, and the nominal increment minus that delta for a backward correction. Because every applied increment is zero or more, the reported time never decreases.

The control is a three-state machine. `ST_IDLE` runs at the nominal rate. `ST_FAST` adds the slew delta on each tick. `ST_SLOW` subtracts it. The machine has four named transitions:
- REQ_POS: a positive request enters `ST_FAST`.
- REQ_NEG: a negative request enters `ST_SLOW`.
- REQ_ZERO: a zero request returns to `ST_IDLE`.
- ABSORB_DONE: the tick that absorbs the last of the remaining amount returns to `ST_IDLE`.

A request that arrives while a slew is under way replaces the remaining amount and raises a sticky overrun flag. On the final tick of a slew, only the remainder is applied.

Top module: `slew_tick_acc`

## Requirements
- R1: After reset the time output is 0, busy and overrun are 0, the nominal increment is 10000 and the slew delta is 5.
- R2: In `ST_IDLE`, each cycle with `tick_i` high adds the nominal increment to the time output, visible on the next cycle.
- R3: In a cycle with neither `tick_i` nor `set_i`, the time output keeps its value.
- R4: In `ST_FAST`, a tick adds the nominal increment plus the step. The step is the smaller of the slew delta and the remaining amount.
- R5: In `ST_SLOW`, a tick adds the nominal increment minus the step.
- R6: A request of magnitude d (`adj_val_i`, two's complement, bit 31 is the sign) raises busy on the next cycle. The slew ends after exactly ceil(d / delta) ticks, and busy falls after the last of those ticks.
- R7: `set_i` loads `set_val_i` on the next cycle. It wins over a tick in the same cycle and leaves any slew in progress untouched.
- R8: `cfg_wr_i` loads the nominal increment and the slew delta. The stored delta is clamped to be no larger than the nominal increment.
- R9: A request issued while busy replaces the remaining amount and direction, and sets `overrun_o`. The flag stays set until reset.
- R10: Without `set_i`, the time output never decreases. An applied increment of zero is allowed.
- R11: A zero-magnitude request leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle periodic tick |
| set_i | input | 1 | Load strobe for the time count |
| set_val_i | input | 64 | Value loaded by `set_i` |
| adj_i | input | 1 | Phase-correction request strobe |
| adj_val_i | input | 32 | Signed correction in microseconds |
| cfg_wr_i | input | 1 | Write strobe for increment and delta |
| cfg_tick_i | input | 16 | New nominal increment |
| cfg_delta_i | input | 16 | New slew delta (clamped) |
| time_o | output | 64 | Time-of-day count in microseconds |
| busy_o | output | 1 | Slew in progress |
| overrun_o | output | 1 | Sticky: a request replaced an unfinished slew |

## Verification
A wrong remaining count or state shows at the ports on the very next tick. It appears as a time step that differs from the nominal increment plus or minus the bounded step, or as busy falling one tick early or late against ceil(d / delta). A corrupted delta clamp shows first as a zero or oversized increment during a backward slew. A lost overrun flag shows at the cycle after a request that overlapped a slew. The bench sweeps small increments, deltas and every correction in a small signed range, and compares each step with an arithmetic model.

// File: rtl/slew_tick_pkg.sv
`timescale 1ns/1ps
package slew_tick_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FAST = 2'd1,
        ST_SLOW = 2'd2
    } slew_state_e;

    typedef enum logic [1:0] {
        RATE_NOM  = 2'd0,
        RATE_FAST = 2'd1,
        RATE_SLOW = 2'd2
    } rate_e;
endpackage

// File: rtl/slew_rate_regs.sv
`timescale 1ns/1ps
module slew_rate_regs #(
    parameter int INC_W     = 16,
    parameter int TICK_RST  = 10000,
    parameter int DELTA_RST = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_i,
    input  logic [INC_W-1:0] cfg_tick_i,
    input  logic [INC_W-1:0] cfg_delta_i,
    output logic [INC_W-1:0] tick_o,
    output logic [INC_W-1:0] delta_o
);
    localparam int DELTA_RST_C = (DELTA_RST > TICK_RST) ? TICK_RST : DELTA_RST;
    localparam logic [INC_W-1:0] TICK_RST_V  = INC_W'(TICK_RST);
    localparam logic [INC_W-1:0] DELTA_RST_V = INC_W'(DELTA_RST_C);

    logic [INC_W-1:0] delta_clamped;

    // the slew delta may never exceed the nominal increment (R8)
    always_comb begin
        delta_clamped = (cfg_delta_i > cfg_tick_i) ? cfg_tick_i : cfg_delta_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_o  <= TICK_RST_V;
            delta_o <= DELTA_RST_V;
        end else if (cfg_wr_i) begin
            tick_o  <= cfg_tick_i;
            delta_o <= delta_clamped;
        end
    end
endmodule

// File: rtl/slew_fsm.sv
`timescale 1ns/1ps
module slew_fsm
    import slew_tick_pkg::*;
#(
    parameter int INC_W = 16,
    parameter int ADJ_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             adj_i,
    input  logic [ADJ_W-1:0] adj_val_i,
    input  logic [INC_W-1:0] delta_i,
    output logic [INC_W-1:0] step_o,
    output rate_e            rate_o,
    output logic             busy_o,
    output logic             overrun_o
);
    slew_state_e      state_q, state_d;
    logic [ADJ_W-1:0] rem_q;
    logic [ADJ_W-1:0] adj_mag;
    logic [ADJ_W-1:0] delta_ext;
    logic             adj_neg;
    logic             last_step;
    logic             in_slew;

    always_comb begin
        adj_neg   = adj_val_i[ADJ_W-1];
        adj_mag   = adj_neg ? (~adj_val_i + 1'b1) : adj_val_i;
        delta_ext = ADJ_W'(delta_i);
        last_step = (rem_q <= delta_ext);
        step_o    = last_step ? rem_q[INC_W-1:0] : delta_i;
        in_slew   = (state_q != ST_IDLE);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: REQ_POS, REQ_NEG, REQ_ZERO, ABSORB_DONE
    always_comb begin
        state_d = state_q;
        if (adj_i) begin
            if (adj_mag == '0)  state_d = ST_IDLE;   // REQ_ZERO
            else if (adj_neg)   state_d = ST_SLOW;   // REQ_NEG
            else                state_d = ST_FAST;   // REQ_POS
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_FAST,
                ST_SLOW: if (tick_i && last_step) state_d = ST_IDLE; // ABSORB_DONE
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // remaining amount still to be absorbed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (adj_i) begin
            rem_q <= adj_mag;
        end else if (tick_i && in_slew) begin
            rem_q <= rem_q - ADJ_W'(step_o);
        end
    end

    // sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n)                overrun_o <= 1'b0;
        else if (adj_i && in_slew) overrun_o <= 1'b1;
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            ST_FAST: begin rate_o = RATE_FAST; busy_o = 1'b1; end
            ST_SLOW: begin rate_o = RATE_SLOW; busy_o = 1'b1; end
            default: begin rate_o = RATE_NOM;  busy_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/time_accum.sv
`timescale 1ns/1ps
module time_accum
    import slew_tick_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int INC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              set_i,
    input  logic [TIME_W-1:0] set_val_i,
    input  logic [INC_W-1:0]  tick_inc_i,
    input  logic [INC_W-1:0]  step_i,
    input  rate_e             rate_i,
    output logic [TIME_W-1:0] time_o
);
    localparam int SUM_W = INC_W + 1;

    logic [SUM_W-1:0] inc;

    always_comb begin
        unique case (rate_i)
            RATE_FAST: inc = {1'b0, tick_inc_i} + {1'b0, step_i};
            RATE_SLOW: inc = {1'b0, tick_inc_i} - {1'b0, step_i};
            default:   inc = {1'b0, tick_inc_i};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      time_o <= '0;
        else if (set_i)  time_o <= set_val_i;
        else if (tick_i) time_o <= time_o + TIME_W'(inc);
    end
endmodule

// File: rtl/slew_tick_acc.sv
`timescale 1ns/1ps
module slew_tick_acc
    import slew_tick_pkg::*;
#(
    parameter int TIME_W    = 64,
    parameter int INC_W     = 16,
    parameter int ADJ_W     = 32,
    parameter int TICK_RST  = 10000,
    parameter int DELTA_RST = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              set_i,
    input  logic [TIME_W-1:0] set_val_i,
    input  logic              adj_i,
    input  logic [ADJ_W-1:0]  adj_val_i,
    input  logic              cfg_wr_i,
    input  logic [INC_W-1:0]  cfg_tick_i,
    input  logic [INC_W-1:0]  cfg_delta_i,
    output logic [TIME_W-1:0] time_o,
    output logic              busy_o,
    output logic              overrun_o
);
    logic [INC_W-1:0] tick_q;
    logic [INC_W-1:0] delta_q;
    logic [INC_W-1:0] step;
    rate_e            rate;

    slew_rate_regs #(
        .INC_W(INC_W), .TICK_RST(TICK_RST), .DELTA_RST(DELTA_RST)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i),
        .cfg_tick_i(cfg_tick_i), .cfg_delta_i(cfg_delta_i),
        .tick_o(tick_q), .delta_o(delta_q)
    );

    slew_fsm #(.INC_W(INC_W), .ADJ_W(ADJ_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .adj_i(adj_i), .adj_val_i(adj_val_i), .delta_i(delta_q),
        .step_o(step), .rate_o(rate), .busy_o(busy_o), .overrun_o(overrun_o)
    );

    time_accum #(.TIME_W(TIME_W), .INC_W(INC_W)) acc_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .set_i(set_i),
        .set_val_i(set_val_i), .tick_inc_i(tick_q), .step_i(step),
        .rate_i(rate), .time_o(time_o)
    );
endmodule

// File: rtl/slew_tick_acc_chk.sv
`timescale 1ns/1ps
module slew_tick_acc_chk #(
    parameter int TIME_W = 64,
    parameter int INC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              set_i,
    input logic [TIME_W-1:0] set_val_i,
    input logic              adj_i,
    input logic              cfg_wr_i,
    input logic [INC_W-1:0]  cfg_tick_i,
    input logic [TIME_W-1:0] time_o,
    input logic              busy_o,
    input logic              overrun_o,
    input logic [INC_W-1:0]  tick_q
);
    // R10
    monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_i |=> time_o >= $past(time_o));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !set_i) |=> $stable(time_o));

    // R7
    set_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> time_o == $past(set_val_i));

    // R2
    nominal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && tick_i && !set_i) |=> time_o == $past(time_o) + TIME_W'($past(tick_q)));

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_i && busy_o) |=> overrun_o);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R8
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i |=> tick_q == $past(cfg_tick_i));
endmodule

bind slew_tick_acc slew_tick_acc_chk #(.TIME_W(TIME_W), .INC_W(INC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .set_i(set_i),
    .set_val_i(set_val_i), .adj_i(adj_i), .cfg_wr_i(cfg_wr_i),
    .cfg_tick_i(cfg_tick_i), .time_o(time_o), .busy_o(busy_o),
    .overrun_o(overrun_o), .tick_q(tick_q)
);

// File: tb/slew_tick_acc_tb.sv
`timescale 1ns/1ps
module slew_tick_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        set_i = 1'b0;
    logic [63:0] set_val_i = '0;
    logic        adj_i = 1'b0;
    logic [31:0] adj_val_i = '0;
    logic        cfg_wr_i = 1'b0;
    logic [15:0] cfg_tick_i = '0;
    logic [15:0] cfg_delta_i = '0;
    logic [63:0] time_o;
    logic        busy_o;
    logic        overrun_o;

    int     checks = 0;
    int     fails = 0;
    bit     done = 1'b0;
    longint m_time = 0;
    int     m_rem = 0;
    bit     m_neg = 1'b0;
    bit     m_ovr = 1'b0;
    int     m_tick = 10000;
    int     m_delta = 5;

    always #10 clk = ~clk;

    slew_tick_acc dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .set_i(set_i),
        .set_val_i(set_val_i), .adj_i(adj_i), .adj_val_i(adj_val_i),
        .cfg_wr_i(cfg_wr_i), .cfg_tick_i(cfg_tick_i), .cfg_delta_i(cfg_delta_i),
        .time_o(time_o), .busy_o(busy_o), .overrun_o(overrun_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " time"}, time_o, 64'(m_time));
        chk({tag, " busy"}, {63'd0, busy_o}, {63'd0, m_rem != 0});
        chk({tag, " overrun"}, {63'd0, overrun_o}, {63'd0, m_ovr});
    endtask

    // drive one cycle of strobes at a falling edge and advance the model
    task automatic drive(input bit t, input bit s, input longint sv, input bit a, input int av);
        bit busy_old;
        int step;
        busy_old = (m_rem != 0);
        step = 0;
        tick_i = t; set_i = s; set_val_i = 64'(sv);
        adj_i = a; adj_val_i = 32'(av);
        if (busy_old) step = (m_rem < m_delta) ? m_rem : m_delta;
        if (s)
            m_time = sv;
        else if (t)
            m_time = m_neg ? m_time + m_tick - step : m_time + m_tick + step;
        if (t && busy_old) m_rem = m_rem - step;
        if (a) begin
            if (busy_old) m_ovr = 1'b1;
            m_rem = (av < 0) ? -av : av;
            m_neg = (av < 0);
        end
        @(negedge clk);
        tick_i = 1'b0; set_i = 1'b0; adj_i = 1'b0;
    endtask

    task automatic cfg(input int t, input int d);
        cfg_wr_i = 1'b1; cfg_tick_i = 16'(t); cfg_delta_i = 16'(d);
        m_tick = t;
        m_delta = (d > t) ? t : d;
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_time = 0; m_rem = 0; m_neg = 1'b0; m_ovr = 1'b0;
        m_tick = 10000; m_delta = 5;
        @(negedge clk);
    endtask

    initial begin
        int tlist [5] = '{1, 2, 3, 7, 10};
        do_reset();
        chk_all("R1 reset");
        drive(1, 0, 0, 0, 0);
        chk("R1 default increment", time_o, 64'd10000);
        // default slew of +12 with delta 5: 10005, 10005, 10002
        drive(0, 0, 0, 1, 12);
        chk_all("R6 default request");
        for (int k = 0; k < 3; k++) begin
            drive(1, 0, 0, 0, 0);
            chk_all("R4 default slew");
        end
        chk("R1 default delta", time_o, 64'd40012);

        // near-exhaustive sweep of increment, delta and correction
        foreach (tlist[ti]) begin
            for (int d = 1; d <= 4; d++) begin
                for (int a = -9; a <= 9; a++) begin
                    int nticks;
                    int expect_n;
                    longint prev;
                    cfg(tlist[ti], d);
                    drive(0, 1, 1000, 0, 0);
                    chk_all("R7 set");
                    drive(0, 0, 0, 1, a);
                    if (a == 0) chk_all("R11 zero request");
                    else        chk_all("R6 request busy");
                    expect_n = ((a < 0 ? -a : a) + m_delta - 1) / m_delta;
                    nticks = 0;
                    while (m_rem != 0 && nticks < 20) begin
                        prev = m_time;
                        drive(1, 0, 0, 0, 0);
                        nticks++;
                        if (a > 0) chk_all("R4 fast tick");
                        else       chk_all("R5 slow tick");
                        chk("R10 monotonic", {63'd0, time_o >= 64'(prev)}, 64'd1);
                    end
                    chk("R6 tick count", 64'(nticks), 64'(expect_n));
                    drive(1, 0, 0, 0, 0);
                    chk_all("R2 idle tick");
                    @(negedge clk);
                    chk_all("R3 hold");
                end
            end
        end

        // clamp: delta 9 requested with increment 3 gives steps of 3
        cfg(3, 9);
        drive(0, 1, 0, 0, 0);
        drive(0, 0, 0, 1, 10);
        drive(1, 0, 0, 0, 0);
        chk("R8 clamped fast step", time_o, 64'd6);
        drive(0, 0, 0, 1, -10);
        drive(1, 0, 0, 0, 0);
        chk("R8 clamped slow step", time_o, 64'd6);
        chk_all("R10 zero increment");

        // overrun: replace an unfinished slew
        cfg(100, 5);
        drive(0, 1, 0, 0, 0);
        drive(0, 0, 0, 1, 20);
        drive(1, 0, 0, 0, 0);
        chk_all("R4 first fast tick");
        drive(0, 0, 0, 1, -7);
        chk_all("R9 overrun raised");
        drive(1, 0, 0, 0, 0);
        chk("R9 replaced direction", time_o, 64'd200);
        drive(1, 0, 0, 0, 0);
        chk("R9 replaced remainder", time_o, 64'd298);
        chk_all("R9 after replace");

        // set and tick together, set during a slew
        drive(1, 1, 5000, 0, 0);
        chk("R7 set beats tick", time_o, 64'd5000);
        drive(0, 0, 0, 1, 8);
        drive(0, 1, 7000, 0, 0);
        chk_all("R7 set keeps slew");
        drive(1, 0, 0, 0, 0);
        chk("R7 slew after set", time_o, 64'd7105);
        drive(1, 0, 0, 0, 0);
        chk_all("R6 remainder tick");
        chk("R9 still sticky", {63'd0, overrun_o}, 64'd1);

        do_reset();
        chk_all("R1 second reset");
        drive(1, 0, 0, 0, 0);
        chk("R1 increment restored", time_o, 64'd10000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule